// File: doc/BRIEF.md
# Scan-Programmed Tapped Sample Delay Line

This block feeds a set of amplifier segments from one stream of digital transmit samples. Each incoming sample enters a register chain that is clocked at the sample rate. Every stage of the chain delays the sample by exactly one sample period. The chain exposes taps from zero delay up to the maximum delay, which is 25 by default and so gives 26 taps. Each output lane has its own multiplexer and selects any one of those taps, with no dependence on the other lanes. Downstream, the segment outputs are summed in the analog domain. The lane selections therefore set the coefficients of an FIR response, and that response can place notches at chosen offsets. With the full 25-sample span, a notch can sit as close as fs/50 to the carrier.

The lane selects are loaded serially. While the scan enable is high, one bit per clock moves into a shadow register. A separate update strobe copies the whole shadow into the active selects in a single cycle. Shifting therefore never disturbs the data path, and a lane never sees a partly loaded select. The scan output carries the bit that leaves the shadow, so several blocks can be chained.

The sample stream is push-only. The block accepts a sample on every cycle where `in_valid` is high and has no ready output, so it never stalls its source. On the output side, `out_valid` marks every cycle in which the lane words were refreshed, and the sink cannot hold the block back.

Top module: `tapped_delay_line`

## Requirements
- R1: After reset, `out_valid` is 0, every lane word is 0, `scan_out` is 0, and every lane uses tap 0. All chain stages hold 0, so delayed taps read 0 until real samples reach them.
- R2: When the chain has accepted samples x[0..n] and lane L has active select s (0 to 25), the cycle after sample x[n] is accepted presents x[n-s] on lane L. It presents 0 if n-s < 0.
- R3: The chain advances only on cycles with `in_valid` high. On cycles without `in_valid`, the lane words keep their values and no sample is lost or repeated.
- R4: `out_valid` is `in_valid` delayed by exactly one cycle, and this latency is the same for all lanes.
- R5: Each lane's select is independent. Any combination of taps across the lanes is honoured at the same time.
- R6: The scan word is LANES*5 bits wide, and lane i owns bits [5i+4:5i]. While `scan_en` is high, each cycle shifts `scan_in` into bit 0 and moves every bit up by one. The word is therefore sent most significant bit first, and its last bit is bit 0 of lane 0.
- R7: `scan_out` always shows the top bit of the shadow register. While a new word is shifting in, the previous word appears on `scan_out`, most significant bit first.
- R8: The active selects change only on a cycle with `scan_update` high, and then take the whole shadow value. Shifting without an update leaves every lane output unchanged.
- R9: A select value above 25 (26 to 31) acts as tap 25.
- R10: When lane 0 is at tap 0 and lane 1 is at tap 25, lane 1 repeats lane 0's sequence exactly 25 accepted samples later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A sample is present and is accepted this cycle |
| in_data | input | SAMPLE_W | Incoming transmit sample |
| scan_en | input | 1 | Shift the select shadow register by one bit |
| scan_in | input | 1 | Serial select data |
| scan_update | input | 1 | Copy the shadow into the active lane selects |
| scan_out | output | 1 | Top bit of the shadow, for cascading |
| out_valid | output | 1 | Lane words were refreshed this cycle |
| out_data | output | LANES*SAMPLE_W | Lane words, lane i at bits [i*SAMPLE_W +: SAMPLE_W] |

## Verification
The bench first sends a long run of samples with every lane at its reset tap. This separates a correct zero-delay path from an off-by-one in the chain. It then sends runs with a distinct tap on every lane, including 0 and 25 together, mixed with idle gaps. Every lane is checked against the sample that many accepted samples earlier, which separates advancing on the clock from advancing on `in_valid`. Selects of 26 and 31 test saturation. A second word is shifted without an update and then with one, which separates the shadow from the active selects and also checks the scan-out bit order.

// File: rtl/tdl_pkg.sv
package tdl_pkg;
  localparam int DEF_SAMPLE_W  = 8;
  localparam int DEF_LANES     = 8;
  localparam int DEF_MAX_DELAY = 25;
endpackage

// File: rtl/tdl_chain.sv
// Register chain clocked at the sample rate; tap 0 is the live input word.
module tdl_chain #(
  parameter int SAMPLE_W  = 8,
  parameter int MAX_DELAY = 25
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                adv,
  input  logic [SAMPLE_W-1:0]                 din,
  output logic [(MAX_DELAY+1)*SAMPLE_W-1:0]   taps
);
  logic [SAMPLE_W-1:0] stg [MAX_DELAY];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < MAX_DELAY; k++) stg[k] <= '0;
    end else if (adv) begin
      stg[0] <= din;
      for (int k = 1; k < MAX_DELAY; k++) stg[k] <= stg[k-1];
    end
  end

  assign taps[SAMPLE_W-1:0] = din;
  for (genvar g = 1; g <= MAX_DELAY; g++) begin : g_tap
    assign taps[g*SAMPLE_W +: SAMPLE_W] = stg[g-1];
  end
endmodule

// File: rtl/tdl_scan_cfg.sv
// Shadow shift register plus active copy taken on the update strobe.
module tdl_scan_cfg #(
  parameter int WORD_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              sin,
  input  logic              upd,
  output logic              sout,
  output logic [WORD_W-1:0] active
);
  logic [WORD_W-1:0] shadow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow <= '0;
      active <= '0;
    end else begin
      if (shift_en) shadow <= {shadow[WORD_W-2:0], sin};
      if (upd)      active <= shadow;
    end
  end

  assign sout = shadow[WORD_W-1];
endmodule

// File: rtl/tdl_lane_mux.sv
// One lane: saturating tap select and registered output word.
module tdl_lane_mux #(
  parameter int SAMPLE_W  = 8,
  parameter int MAX_DELAY = 25,
  parameter int SEL_W     = 5
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              adv,
  input  logic [SEL_W-1:0]                  sel,
  input  logic [(MAX_DELAY+1)*SAMPLE_W-1:0] taps,
  output logic [SAMPLE_W-1:0]               dout
);
  localparam logic [SEL_W-1:0] TOP = SEL_W'(MAX_DELAY);

  logic [SEL_W-1:0]    eff;
  logic [SAMPLE_W-1:0] picked;

  assign eff = (sel > TOP) ? TOP : sel;

  always_comb begin
    picked = '0;
    for (int k = 0; k <= MAX_DELAY; k++)
      if (eff == SEL_W'(k)) picked = taps[k*SAMPLE_W +: SAMPLE_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   dout <= '0;
    else if (adv) dout <= picked;
  end
endmodule

// File: rtl/tapped_delay_line.sv
module tapped_delay_line #(
  parameter int SAMPLE_W  = tdl_pkg::DEF_SAMPLE_W,
  parameter int LANES     = tdl_pkg::DEF_LANES,
  parameter int MAX_DELAY = tdl_pkg::DEF_MAX_DELAY
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [SAMPLE_W-1:0]       in_data,
  input  logic                      scan_en,
  input  logic                      scan_in,
  input  logic                      scan_update,
  output logic                      scan_out,
  output logic                      out_valid,
  output logic [LANES*SAMPLE_W-1:0] out_data
);
  localparam int SEL_W  = $clog2(MAX_DELAY + 1);
  localparam int WORD_W = LANES * SEL_W;
  localparam int TAP_W  = (MAX_DELAY + 1) * SAMPLE_W;

  logic [TAP_W-1:0]  taps;
  logic [WORD_W-1:0] act_sel;

  tdl_chain #(.SAMPLE_W(SAMPLE_W), .MAX_DELAY(MAX_DELAY)) u_chain (
    .clk(clk), .rst_n(rst_n), .adv(in_valid), .din(in_data), .taps(taps)
  );

  tdl_scan_cfg #(.WORD_W(WORD_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .shift_en(scan_en), .sin(scan_in),
    .upd(scan_update), .sout(scan_out), .active(act_sel)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    tdl_lane_mux #(.SAMPLE_W(SAMPLE_W), .MAX_DELAY(MAX_DELAY), .SEL_W(SEL_W)) u_mux (
      .clk(clk), .rst_n(rst_n), .adv(in_valid),
      .sel(act_sel[l*SEL_W +: SEL_W]), .taps(taps),
      .dout(out_data[l*SAMPLE_W +: SAMPLE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end
endmodule

// File: rtl/tdl_checker.sv
module tdl_checker #(
  parameter int SAMPLE_W = 8,
  parameter int LANES    = 8,
  parameter int SEL_W    = 5
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      in_valid,
  input logic [SAMPLE_W-1:0]       in_data,
  input logic                      scan_en,
  input logic                      scan_update,
  input logic                      scan_out,
  input logic                      out_valid,
  input logic [LANES*SAMPLE_W-1:0] out_data,
  input logic [LANES*SEL_W-1:0]    act_sel
);
  assert_valid_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_on_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));
  assert_sel_needs_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_update |=> $stable(act_sel));
  assert_scan_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> $stable(scan_out));
  assert_tap0_passes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && act_sel[SEL_W-1:0] == '0) |=> out_data[SAMPLE_W-1:0] == $past(in_data));
endmodule

bind tapped_delay_line tdl_checker #(.SAMPLE_W(SAMPLE_W), .LANES(LANES), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
  .scan_en(scan_en), .scan_update(scan_update), .scan_out(scan_out),
  .out_valid(out_valid), .out_data(out_data), .act_sel(act_sel)
);

// File: tb/sim_tapped_delay_line.sv
module sim_tapped_delay_line;
  localparam int SW = 8;
  localparam int LN = 8;
  localparam int MD = 25;
  localparam int SL = 5;
  localparam int WW = LN * SL;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [SW-1:0] in_data = '0;
  logic scan_en = 1'b0, scan_in = 1'b0, scan_update = 1'b0;
  logic scan_out, out_valid;
  logic [LN*SW-1:0] out_data;

  always #2.5 clk = ~clk;

  tapped_delay_line #(.SAMPLE_W(SW), .LANES(LN), .MAX_DELAY(MD)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .scan_en(scan_en), .scan_in(scan_in), .scan_update(scan_update),
    .scan_out(scan_out), .out_valid(out_valid), .out_data(out_data)
  );

  int total = 0, bad = 0;
  string tag = "R1";
  logic [LN*SW-1:0] exp_q[$];
  logic [SW-1:0] hist [0:1023];
  int n_sent = 0;
  int tb_sel [LN];
  logic [WW-1:0] tb_shadow = '0;
  logic [LN*SW-1:0] last_out = '0;
  bit mon_on = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Driver: pushes the sample and the per-lane expectation it implies.
  task automatic push(input logic [SW-1:0] d);
    logic [LN*SW-1:0] e;
    hist[n_sent] = d;
    for (int l = 0; l < LN; l++) begin
      int s = (tb_sel[l] > MD) ? MD : tb_sel[l];
      int idx = n_sent - s;
      e[l*SW +: SW] = (idx >= 0) ? hist[idx] : '0;
    end
    exp_q.push_back(e);
    n_sent++;
    in_valid = 1'b1; in_data = d;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic idle(input int k);
    repeat (k) begin @(posedge clk); #1; end
  endtask

  task automatic burst(input int cnt, input int seed, input bit gaps);
    for (int i = 0; i < cnt; i++) begin
      push(SW'(i * 37 + seed * 11 + 5));
      if (gaps && (i % 4 == 3)) idle(2);
    end
  endtask

  // Shift a select word MSB first; optionally check the previous word on scan_out.
  task automatic scan_load(input logic [WW-1:0] word, input bit do_upd, input bit chk_out);
    for (int j = WW - 1; j >= 0; j--) begin
      scan_en = 1'b1; scan_in = word[j];
      if (chk_out) chk(scan_out == tb_shadow[WW-1], "R7", scan_out, tb_shadow[WW-1]);
      @(posedge clk); #1;
      tb_shadow = {tb_shadow[WW-2:0], word[j]};
    end
    scan_en = 1'b0;
    if (do_upd) begin
      scan_update = 1'b1;
      @(posedge clk); #1;
      scan_update = 1'b0;
      for (int l = 0; l < LN; l++) tb_sel[l] = int'(tb_shadow[l*SL +: SL]);
    end
  endtask

  function automatic logic [WW-1:0] mkword(input int a0, a1, a2, a3, a4, a5, a6, a7);
    logic [WW-1:0] w;
    w[0*SL +: SL] = SL'(a0); w[1*SL +: SL] = SL'(a1);
    w[2*SL +: SL] = SL'(a2); w[3*SL +: SL] = SL'(a3);
    w[4*SL +: SL] = SL'(a4); w[5*SL +: SL] = SL'(a5);
    w[6*SL +: SL] = SL'(a6); w[7*SL +: SL] = SL'(a7);
    return w;
  endfunction

  // Monitor: pops and compares on every refreshed output.
  always @(negedge clk) begin
    if (mon_on) begin
      if (out_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R4", 1, 0);
        else begin
          logic [LN*SW-1:0] e;
          e = exp_q.pop_front();
          for (int l = 0; l < LN; l++)
            chk(out_data[l*SW +: SW] == e[l*SW +: SW], tag, out_data[l*SW +: SW], e[l*SW +: SW]);
        end
      end else begin
        chk(out_data == last_out, "R3", out_data, last_out);
      end
      last_out = out_data;
    end
  end

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    chk(1'b0, "watchdog", cyc, 100000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int l = 0; l < LN; l++) tb_sel[l] = 0;
    idle(3);
    @(negedge clk);
    chk(out_data == '0, "R1", out_data, 0);
    chk(out_valid == 1'b0, "R1", out_valid, 0);
    chk(scan_out == 1'b0, "R1", scan_out, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    mon_on = 1'b1;
    // R1: all lanes at tap 0 after reset
    tag = "R1"; burst(30, 1, 1'b0);
    idle(3);
    // R2, R5, R6: distinct tap per lane, with idle gaps for R3
    tag = "R2"; scan_load(mkword(0, 3, 6, 9, 12, 15, 18, 21), 1'b1, 1'b0);
    burst(40, 2, 1'b1);
    // R10: lanes 0 and 1 at taps 0 and 25
    tag = "R10"; scan_load(mkword(0, 25, 1, 24, 7, 2, 13, 5), 1'b1, 1'b1);
    burst(60, 3, 1'b0);
    burst(20, 4, 1'b1);
    // R8: shift a new word without update; outputs must keep old taps
    tag = "R8"; scan_load(mkword(4, 4, 4, 4, 4, 4, 4, 4), 1'b0, 1'b1);
    burst(30, 5, 1'b1);
    scan_update = 1'b1; @(posedge clk); #1; scan_update = 1'b0;
    for (int l = 0; l < LN; l++) tb_sel[l] = int'(tb_shadow[l*SL +: SL]);
    burst(30, 6, 1'b0);
    // R9: saturated selects, and R6 bit order with top lane values
    tag = "R9"; scan_load(mkword(25, 0, 31, 26, 30, 8, 16, 1), 1'b1, 1'b1);
    burst(50, 7, 1'b1);
    idle(5);
    chk(exp_q.size() == 0, "R4", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule